// File: doc/BRIEF.md
# Multi-Function Nibble ALU

This block is a purely combinational arithmetic logic unit for two unsigned 4-bit operands. A 3-bit function select picks one of several sub-unit results and presents it as an unsigned 8-bit value. Each operation has its own sub-unit, and an output multiplexer chooses between them. The operations are:

- an increment and an addition that both run through a structural ripple-carry adder built from full-adder cells;
- a second addition written with the behavioural `+` operator;
- a mixed XOR/OR over the two nibbles;
- a one-bit "any bit set" flag over both operands;
- a concatenation of the two operands.

Alongside the binary result, the block drives four active-low seven-segment digits. One shows operand A, one shows operand B, and two show the high and low nibbles of the result. The block has no clock and no state. Whatever sits on the inputs appears on the outputs after the combinational delay.

Top module: `small_alu`

## Requirements
- R1: With func_sel = 0, result equals op_a + 1, zero-extended to 8 bits. The sum comes from the ripple-carry adder with carry-in 1 and second operand 0, so op_a = 15 gives 16.
- R2: With func_sel = 1, result equals op_a + op_b from the four-cell ripple-carry adder. Its carry-out lands in result bit 4, and bits 7..5 are 0.
- R3: With func_sel = 2, result equals op_a + op_b from a behavioural adder, zero-extended. For every operand pair it is identical to the func_sel = 1 result.
- R4: With func_sel = 3, result bits 3..0 hold op_a XOR op_b and result bits 7..4 hold op_a OR op_b.
- R5: With func_sel = 4, result is 8'h01 when any of the eight bits of op_a and op_b is 1, and 8'h00 when all eight are 0.
- R6: With func_sel = 5, result bits 7..4 hold op_a and result bits 3..0 hold op_b.
- R7: With func_sel = 6 or 7, result is 8'h00 whatever the operands are.
- R8: seg_a_n and seg_b_n show op_a and op_b as hexadecimal glyphs. Each is active-low with bit order {g,f,e,d,c,b,a}. The lit-segment patterns (active-high, g..a) for values 0..F are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R9: seg_hi_n shows result bits 7..4 and seg_lo_n shows result bits 3..0, using the same active-low encoding as R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 4 | Unsigned operand A |
| op_b | input | 4 | Unsigned operand B |
| func_sel | input | 3 | Operation select code |
| result | output | 8 | Unsigned operation result |
| seg_a_n | output | 7 | Active-low digit for op_a, {g,f,e,d,c,b,a} |
| seg_b_n | output | 7 | Active-low digit for op_b |
| seg_hi_n | output | 7 | Active-low digit for result[7:4] |
| seg_lo_n | output | 7 | Active-low digit for result[3:0] |

## Verification
Both the structural ripple adder and the behavioural adder evaluate every operand pair in the same cycle, though only one of them reaches the output. The bench applies all 256 operand pairs under func_sel 1 and again under func_sel 2, and records both sums per pair. At the end it requires the two records to match pair by pair. In every cycle the four digit outputs are also judged together with the binary result they encode. A wrong digit decode therefore shows up in the same cycle as a wrong sum.

// File: rtl/small_alu_pkg.sv
package small_alu_pkg;
  localparam logic [2:0] FN_INC    = 3'd0;
  localparam logic [2:0] FN_RIPPLE = 3'd1;
  localparam logic [2:0] FN_BEHAV  = 3'd2;
  localparam logic [2:0] FN_XOR_OR = 3'd3;
  localparam logic [2:0] FN_ANY    = 3'd4;
  localparam logic [2:0] FN_CAT    = 3'd5;
endpackage

// File: rtl/full_adder_cell.sv
module full_adder_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic p;
  assign p  = a ^ b;
  assign s  = p ^ ci;
  assign co = (a & b) | (ci & p);
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_stage
    full_adder_cell u_fa (
      .a (x[i]),
      .b (y[i]),
      .ci(chain[i]),
      .s (sum[i]),
      .co(chain[i+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/hex_seg_decoder.sv
module hex_seg_decoder (
  input  logic [3:0] nib,
  output logic [6:0] seg_n
);
  logic [6:0] lit;
  always_comb begin
    unique case (nib)
      4'h0: lit = 7'h3F;
      4'h1: lit = 7'h06;
      4'h2: lit = 7'h5B;
      4'h3: lit = 7'h4F;
      4'h4: lit = 7'h66;
      4'h5: lit = 7'h6D;
      4'h6: lit = 7'h7D;
      4'h7: lit = 7'h07;
      4'h8: lit = 7'h7F;
      4'h9: lit = 7'h6F;
      4'hA: lit = 7'h77;
      4'hB: lit = 7'h7C;
      4'hC: lit = 7'h39;
      4'hD: lit = 7'h5E;
      4'hE: lit = 7'h79;
      default: lit = 7'h71;
    endcase
  end
  assign seg_n = ~lit;
endmodule

// File: rtl/small_alu.sv
module small_alu #(
  parameter int NW = 4
) (
  input  logic [NW-1:0]   op_a,
  input  logic [NW-1:0]   op_b,
  input  logic [2:0]      func_sel,
  output logic [2*NW-1:0] result,
  output logic [6:0]      seg_a_n,
  output logic [6:0]      seg_b_n,
  output logic [6:0]      seg_hi_n,
  output logic [6:0]      seg_lo_n
);
  import small_alu_pkg::*;

  localparam int RW  = 2 * NW;
  localparam int PAD = RW - NW - 1;

  // Increment path: ripple adder, second operand zero, carry-in one
  logic [NW-1:0] inc_s;
  logic          inc_co;
  ripple_adder #(.W(NW)) u_inc (
    .x   (op_a),
    .y   ('0),
    .cin (1'b1),
    .sum (inc_s),
    .cout(inc_co)
  );

  // Structural sum path
  logic [NW-1:0] rip_s;
  logic          rip_co;
  ripple_adder #(.W(NW)) u_rip (
    .x   (op_a),
    .y   (op_b),
    .cin (1'b0),
    .sum (rip_s),
    .cout(rip_co)
  );

  // Behavioural sum path
  logic [RW-1:0] beh_s;
  assign beh_s = RW'(op_a) + RW'(op_b);

  // Output multiplexer
  always_comb begin
    unique case (func_sel)
      FN_INC:    result = {{PAD{1'b0}}, inc_co, inc_s};
      FN_RIPPLE: result = {{PAD{1'b0}}, rip_co, rip_s};
      FN_BEHAV:  result = beh_s;
      FN_XOR_OR: result = {op_a | op_b, op_a ^ op_b};
      FN_ANY:    result = {{(RW-1){1'b0}}, |{op_a, op_b}};
      FN_CAT:    result = {op_a, op_b};
      default:   result = '0;
    endcase
  end

  hex_seg_decoder u_dig_a  (.nib(op_a),            .seg_n(seg_a_n));
  hex_seg_decoder u_dig_b  (.nib(op_b),            .seg_n(seg_b_n));
  hex_seg_decoder u_dig_hi (.nib(result[RW-1:NW]), .seg_n(seg_hi_n));
  hex_seg_decoder u_dig_lo (.nib(result[NW-1:0]),  .seg_n(seg_lo_n));
endmodule

// File: rtl/small_alu_checks.sv
module small_alu_checks #(
  parameter int NW = 4
) (
  input logic [NW-1:0]   op_a,
  input logic [NW-1:0]   op_b,
  input logic [2:0]      func_sel,
  input logic [2*NW-1:0] result
);
  localparam int RW = 2 * NW;

  always_comb begin
    if (func_sel == 3'd0)
      a_r1_increment: assert (result == RW'(op_a) + RW'(1));
    if (func_sel == 3'd1)
      a_r2_top_bits_clear: assert (result[RW-1:NW+1] == '0);
    if (func_sel == 3'd1 || func_sel == 3'd2)
      a_r3_sum_matches: assert (result == RW'(op_a) + RW'(op_b));
    if (func_sel == 3'd3)
      a_r4_split_logic: assert (result[NW-1:0] == (op_a ^ op_b) && result[RW-1:NW] == (op_a | op_b));
    if (func_sel == 3'd4)
      a_r5_flag_value: assert (result == ((op_a != '0 || op_b != '0) ? RW'(1) : RW'(0)));
    if (func_sel == 3'd5)
      a_r6_concat: assert (result[RW-1:NW] == op_a && result[NW-1:0] == op_b);
    if (func_sel[2:1] == 2'b11)
      a_r7_unused_zero: assert (result == '0);
  end
endmodule

bind small_alu small_alu_checks #(.NW(NW)) u_chk (
  .op_a    (op_a),
  .op_b    (op_b),
  .func_sel(func_sel),
  .result  (result)
);

// File: tb/sim_small_alu.sv
module sim_small_alu;
  logic clk;
  logic rst_n;
  logic [3:0] op_a, op_b;
  logic [2:0] func_sel;
  logic [7:0] result;
  logic [6:0] seg_a_n, seg_b_n, seg_hi_n, seg_lo_n;

  typedef struct packed {
    logic [2:0] fn;
    logic [3:0] a;
    logic [3:0] b;
    logic [7:0] res;
  } item_t;

  item_t      sb_q[$];
  int         n_checks;
  int         n_errors;
  logic [7:0] sum_rip [256];
  logic [7:0] sum_beh [256];
  bit         done;

  small_alu u0 (
    .op_a(op_a), .op_b(op_b), .func_sel(func_sel), .result(result),
    .seg_a_n(seg_a_n), .seg_b_n(seg_b_n), .seg_hi_n(seg_hi_n), .seg_lo_n(seg_lo_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [6:0] glyph_n(input logic [3:0] v);
    logic [6:0] g;
    case (v)
      4'h0: g = 7'h3F; 4'h1: g = 7'h06; 4'h2: g = 7'h5B; 4'h3: g = 7'h4F;
      4'h4: g = 7'h66; 4'h5: g = 7'h6D; 4'h6: g = 7'h7D; 4'h7: g = 7'h07;
      4'h8: g = 7'h7F; 4'h9: g = 7'h6F; 4'hA: g = 7'h77; 4'hB: g = 7'h7C;
      4'hC: g = 7'h39; 4'hD: g = 7'h5E; 4'hE: g = 7'h79; default: g = 7'h71;
    endcase
    return ~g;
  endfunction

  function automatic logic [7:0] ref_model(input logic [2:0] fn, input logic [3:0] a, input logic [3:0] b);
    int s;
    case (fn)
      3'd0: s = int'(a) + 1;
      3'd1, 3'd2: s = int'(a) + int'(b);
      3'd3: return {a | b, a ^ b};
      3'd4: return ({a, b} != 8'h00) ? 8'h01 : 8'h00;
      3'd5: return {a, b};
      default: return 8'h00;
    endcase
    return s[7:0];
  endfunction

  task automatic drive(input logic [2:0] fn, input logic [3:0] a, input logic [3:0] b);
    item_t it;
    @(posedge clk);
    op_a = a; op_b = b; func_sel = fn;
    it.fn = fn; it.a = a; it.b = b; it.res = ref_model(fn, a, b);
    sb_q.push_back(it);
  endtask

  task automatic fail_line(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_errors++;
    $display("FAIL %s: actual=%h expected=%h", req, act, exp);
  endtask

  // Monitor: sample away from the driving edge
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      item_t it;
      string tag;
      it = sb_q.pop_front();
      case (it.fn)
        3'd0: tag = "R1";
        3'd1: tag = "R2";
        3'd2: tag = "R3";
        3'd3: tag = "R4";
        3'd4: tag = "R5";
        3'd5: tag = "R6";
        default: tag = "R7";
      endcase
      n_checks++;
      if (result !== it.res) fail_line(tag, {8'h0, result}, {8'h0, it.res});
      if (it.fn == 3'd1) sum_rip[{it.a, it.b}] = result;
      if (it.fn == 3'd2) sum_beh[{it.a, it.b}] = result;
      n_checks++; // R8 operand digits
      if (seg_a_n !== glyph_n(it.a) || seg_b_n !== glyph_n(it.b))
        fail_line("R8", {1'b0, seg_a_n, 1'b0, seg_b_n},
                  {1'b0, glyph_n(it.a), 1'b0, glyph_n(it.b)});
      n_checks++; // R9 result digits
      if (seg_hi_n !== glyph_n(it.res[7:4]) || seg_lo_n !== glyph_n(it.res[3:0]))
        fail_line("R9", {1'b0, seg_hi_n, 1'b0, seg_lo_n},
                  {1'b0, glyph_n(it.res[7:4]), 1'b0, glyph_n(it.res[3:0])});
    end
  end

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    n_checks++;
    fail_line("watchdog", 16'(cyc), 16'h0);
    summary();
  end

  initial begin
    n_checks = 0; n_errors = 0; done = 1'b0;
    rst_n = 1'b0;
    op_a = 4'h0; op_b = 4'h0; func_sel = 3'd6;
    repeat (3) @(posedge clk);
    #1;
    n_checks++; // reset-time state, R7: code 6 yields zero
    if (result !== 8'h00) fail_line("R7", {8'h0, result}, 16'h0);
    @(posedge clk);
    rst_n = 1'b1;
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 256; p++)
        drive(3'(f), 4'(p >> 4), 4'(p));
    // Boundary patterns: carry into bit 4, all-zero flag, single high bit
    drive(3'd0, 4'hF, 4'h0);
    drive(3'd1, 4'hF, 4'h1);
    drive(3'd4, 4'h0, 4'h0);
    drive(3'd4, 4'h8, 4'h0);
    drive(3'd7, 4'hF, 4'hF);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    for (int p = 0; p < 256; p++) begin
      n_checks++; // R3: both adders agree
      if (sum_rip[p] !== sum_beh[p]) fail_line("R3", {8'h0, sum_beh[p]}, {8'h0, sum_rip[p]});
    end
    summary();
  end
endmodule